// File: doc/BRIEF.md
# Two-Key Register Write Lock

This block sits on the write path of a peripheral's register file and decides, write by write, whether a register update may take effect. Protected registers at the low end of the address map (time, alarm, control, status and interrupt registers) only accept writes after software has written two 32-bit key words, one into each of two kick registers, in a fixed order. Any other value written to a kick register clears the unlock progress and locks the block again. Writing zero to the kick registers is the normal way to lock it.

The block observes a plain address / write-data / write-enable bus. It drives one write-allow output that the register file uses as its write strobe. It also drives a kick-select output that the read mux uses to return zero for the kick registers. Reads never pass through the gate and are never blocked. Writes to addresses at or above the protected limit pass regardless of the lock state.

Top module: `regwr_keygate`

## Requirements
- R1: After reset the block is locked, so a write with `bus_we`=1 to a protected address (below `PROT_LIMIT`, default 0x4C) gives `wr_allow`=0.
- R2: A write of 0x83E70B13 to the first kick register (0x6C), followed later by a write of 0x95A4F1E0 to the second kick register (0x70), unlocks the block. From the cycle after the second write, protected writes give `wr_allow`=1.
- R3: A correct second key written while no correct first key is pending leaves the block locked.
- R4: Writing any value other than its own key to either kick register locks the block from the next cycle and discards a pending first key. The full two-key sequence is then needed again.
- R5: Writing 0 to a kick register while the block is unlocked locks it again from the next cycle.
- R6: Writes to addresses at or above `PROT_LIMIT` that are not kick registers give `wr_allow`=`bus_we` in every lock state. Address 0x4B counts as protected; 0x4C does not.
- R7: `kick_sel` is 1 exactly when `bus_addr` equals 0x6C or 0x70. A write to a kick register is never forwarded (`wr_allow`=0), so the read path returns zero for these addresses.
- R8: `wr_allow` is 0 whenever `bus_we` is 0.
- R9: Writes to non-kick addresses never change the lock state. Writing the first key again leaves a pending first key pending and keeps an unlocked block unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW (8) | Byte address of the current access |
| bus_wdata | input | DW (32) | Write data |
| bus_we | input | 1 | Write strobe |
| wr_allow | output | 1 | Write enable forwarded to the register file |
| kick_sel | output | 1 | Address decodes to a kick register; read data must be forced to zero |

## Verification
The lock state is only visible through `wr_allow` on protected addresses, and it shows there in the cycle after a kick write. A state that is wrongly held open lets a protected write through at once. A lost pending first key only shows up when the second key then fails to unlock. For that reason the bench probes a protected address directly after every kick write. It also places protected writes between the two keys, so that corrupted progress appears within one or two cycles.

// File: rtl/regwr_keygate.sv
module regwr_keygate #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter logic [AW-1:0] KICK_A_ADDR = 8'h6C,
  parameter logic [AW-1:0] KICK_B_ADDR = 8'h70,
  parameter logic [DW-1:0] KEY_A = 32'h83E70B13,
  parameter logic [DW-1:0] KEY_B = 32'h95A4F1E0,
  parameter logic [AW-1:0] PROT_LIMIT = 8'h4C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_we,
  output logic          wr_allow,
  output logic          kick_sel
);

  typedef enum logic [1:0] {LOCKED = 2'd0, HALF = 2'd1, OPEN = 2'd2} lock_t;

  lock_t st, st_nx;
  logic hit_a, hit_b, prot, good_a, good_b;

  assign hit_a  = (bus_addr == KICK_A_ADDR);
  assign hit_b  = (bus_addr == KICK_B_ADDR);
  assign prot   = (bus_addr < PROT_LIMIT);
  assign good_a = (bus_wdata == KEY_A);
  assign good_b = (bus_wdata == KEY_B);

  always_comb begin
    st_nx = st;
    if (bus_we && hit_a)
      st_nx = !good_a ? LOCKED : (st == OPEN ? OPEN : HALF);
    else if (bus_we && hit_b)
      st_nx = !good_b ? LOCKED : (st == LOCKED ? LOCKED : OPEN);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= LOCKED;
    else        st <= st_nx;

  assign kick_sel = hit_a | hit_b;
  assign wr_allow = bus_we && !kick_sel && (!prot || st == OPEN);

  a_r2_open_needs_key_b: assert property (@(posedge clk) disable iff (!rst_n)
    (st == OPEN && $past(st) != OPEN) |-> $past(bus_we && hit_b && good_b && st == HALF));

  a_r4_bad_kick_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && ((hit_a && !good_a) || (hit_b && !good_b))) |=> (st == LOCKED));

  a_r9_other_writes_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_sel) |=> $stable(st));

  a_r6_unprot_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !prot && !kick_sel) |-> wr_allow);

  a_r7_kick_not_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
    kick_sel |-> !wr_allow);

  a_r8_no_we_no_allow: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |-> !wr_allow);

endmodule

// File: tb/regwr_keygate_test.sv
module regwr_keygate_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 1'b0;
  logic wr_allow, kick_sel;

  int errors = 0, checks = 0, mstate = 0;
  bit done = 0;

  localparam logic [31:0] KA = 32'h83E70B13, KB = 32'h95A4F1E0;

  always #4 clk = ~clk;

  regwr_keygate uut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .wr_allow(wr_allow), .kick_sel(kick_sel));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic step(input logic [7:0] a, input logic [31:0] d, input logic we, input string tag);
    logic ek, ea;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we;
    #1;
    ek = (a == 8'h6C) || (a == 8'h70);
    ea = we && !ek && (a >= 8'h4C || mstate == 2);
    checks++;
    if (wr_allow !== ea || kick_sel !== ek) begin
      errors++;
      $display("FAIL %s addr=%h: wr_allow=%b kick_sel=%b expected %b %b", tag, a, wr_allow, kick_sel, ea, ek);
    end
    @(posedge clk);
    if (we && a == 8'h6C) mstate = (d != KA) ? 0 : (mstate == 2 ? 2 : 1);
    else if (we && a == 8'h70) mstate = (d != KB) ? 0 : (mstate == 0 ? 0 : 2);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(8'h00, 32'h12, 1, "R1 reset locked");
    step(8'h54, 32'h1, 1, "R6 unprotected while locked");
    step(8'h08, 32'h1, 0, "R8 no write strobe");
    step(8'h70, KB, 1, "R3 second key first");
    step(8'h08, 32'h5, 1, "R3 still locked");
    step(8'h6C, KA, 1, "R2 first key");
    step(8'h10, 32'h5, 1, "R9 protected write between keys");
    step(8'h6C, KA, 1, "R9 first key repeated");
    step(8'h70, KB, 1, "R2 second key");
    step(8'h40, 32'h7, 1, "R2 unlocked write");
    step(8'h4B, 32'h7, 1, "R6 boundary 0x4B");
    step(8'h40, 32'h7, 0, "R8 no strobe while open");
    step(8'h6C, KA, 1, "R9 first key while open");
    step(8'h00, 32'h9, 1, "R9 still open");
    step(8'h6C, 32'h0, 1, "R5 zero relock");
    step(8'h00, 32'h9, 1, "R5 locked after zero");
    step(8'h70, 32'h0, 1, "R5 zero second kick");
    step(8'h4C, 32'h9, 1, "R6 boundary 0x4C");
    step(8'h6C, KA, 1, "R4 setup first key");
    step(8'h70, KB, 1, "R4 setup second key");
    step(8'h70, 32'hDEADBEEF, 1, "R4 bad second kick");
    step(8'h04, 32'h9, 1, "R4 locked after bad value");
    step(8'h6C, KA, 1, "R4 first key");
    step(8'h6C, KB, 1, "R4 wrong first kick value");
    step(8'h70, KB, 1, "R4 progress discarded");
    step(8'h04, 32'h9, 1, "R4 still locked");
    step(8'h70, 32'h0, 0, "R7 kick read select");
    step(8'h6C, KA, 1, "R7 kick not forwarded");
    step(8'h70, KB, 1, "R7 kick not forwarded");
    step(8'h2C, 32'h1, 1, "R2 unlocked again");
    finish_run();
  end
endmodule